// File: doc/BRIEF.md
# Compare and Auto-Reload System Timer

A memory-mapped system timer for a larger chip, built around a free-running 64-bit up-counter that advances by one on every clock edge where the tick-enable input is high. Two interrupt sources share one level-sensitive interrupt output. The first is a one-shot compare unit, programmed either as an absolute 64-bit deadline or through a signed 32-bit relative view that measures the distance from the current count. The second is a periodic unit that loads a deadline of count plus a 32-bit reload, raises a sticky flag when the deadline is reached, and re-arms itself at once. While the periodic unit is switched on, it is the only interrupt source and the compare path is silent.

Software reaches the timer through a single-cycle word bus with a 4 KB window. A read returns data combinationally in the cycle the address is presented. A write takes effect at the next rising clock edge. The 64-bit values are read as two halves that are not latched together, so software has to deal with tearing between them. A configuration word reports that the periodic unit is present, and a block of identification words at the top of the window reads back fixed byte values.

Top module: `cmp_reload_timer`

## Requirements
- R1: The count resets to 0 and increments by one on each clock edge where `tick_en` is 1; it is readable at 0x000 (low half) and 0x004 (high half), and writes there are ignored.
- R2: Offset 0x010 holds a 32-bit frequency word that reads back whatever was last written.
- R3: The 64-bit compare value is read and written as two halves, low at 0x020 and high at 0x024; writing one half leaves the other half unchanged.
- R4: A read of 0x028 returns the low 32 bits of (compare minus count); a write there sets the compare value to the count plus the written word sign-extended to 64 bits.
- R5: At 0x02C, bit 0 is the enable and bit 1 is the mask, and both are writable; bit 2 reads the status and cannot be written; all other bits read 0.
- R6: The status is 0 while the enable is 0. With the periodic unit off, the status is 1 when count >= compare (unsigned). The interrupt output equals status AND NOT mask.
- R7: At 0x04C, bit 0 turns the periodic unit on and bit 1 is its flag. Writing 0 to bit 1 clears the flag, and writing 1 to it leaves the flag as it was. Reads of 0x04C return 0.
- R8: A write that leaves both the enable and the periodic-unit bit set, having changed either of them, loads the deadline with count plus reload. The reload is a read/write word at 0x048, and the deadline reads at 0x040 (low half) and 0x044 (high half).
- R9: With both the enable and the periodic-unit bit set, a count >= deadline at a clock edge sets the flag and reloads the deadline with count plus reload at that edge. The status then equals the flag, and the compare result is ignored.
- R10: Offset 0x050 reads 1. The twelve words from 0xFD0 to 0xFFC read 0x04, 0x00, 0x00, 0x00, 0xB7, 0xB0, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order.
- R11: Reads of unmapped offsets return 0, and writes to read-only offsets change nothing.
- R12: While `rst_n` is low at a clock edge, the count, frequency, control, compare, deadline, periodic-unit control and reload all return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word-aligned byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes a negative relative value so that the compare point falls behind the count. A design that added the value without sign extension would set a deadline about four billion ticks ahead and never fire. It sets the mask while the compare condition holds and checks that the status bit is still 1 with the interrupt low. A design that gated the status with the mask would lose the visible status. It runs the periodic unit through two expiries, checks the reloaded deadline each time, writes 1 and then 0 to the flag, and switches back to compare mode while the compare condition is already true. A design that kept the compare path live, let a write of 1 clear the flag, or re-armed on every control write would give a wrong interrupt level or a wrong deadline value.

// File: rtl/crt_pkg.sv
// Shared register offsets and the identification lookup for the timer.
// Assumes word-aligned 12-bit byte offsets inside a 4 KB window.
package crt_pkg;
    localparam int          ADDR_W        = 12;
    localparam logic [11:0] OFF_COUNT_LO  = 12'h000;
    localparam logic [11:0] OFF_COUNT_HI  = 12'h004;
    localparam logic [11:0] OFF_FREQ      = 12'h010;
    localparam logic [11:0] OFF_CMP_LO    = 12'h020;
    localparam logic [11:0] OFF_CMP_HI    = 12'h024;
    localparam logic [11:0] OFF_REL       = 12'h028;
    localparam logic [11:0] OFF_CTRL      = 12'h02C;
    localparam logic [11:0] OFF_DL_LO     = 12'h040;
    localparam logic [11:0] OFF_DL_HI     = 12'h044;
    localparam logic [11:0] OFF_RELOAD    = 12'h048;
    localparam logic [11:0] OFF_AUTO_CTRL = 12'h04C;
    localparam logic [11:0] OFF_CFG       = 12'h050;

    // Identification byte for an address in the top block, 0 elsewhere.
    function automatic logic [7:0] id_byte(input logic [11:0] addr);
        case (addr)
            12'hFD0: id_byte = 8'h04;
            12'hFD4: id_byte = 8'h00;
            12'hFD8: id_byte = 8'h00;
            12'hFDC: id_byte = 8'h00;
            12'hFE0: id_byte = 8'hB7;
            12'hFE4: id_byte = 8'hB0;
            12'hFE8: id_byte = 8'h0B;
            12'hFEC: id_byte = 8'h00;
            12'hFF0: id_byte = 8'h0D;
            12'hFF4: id_byte = 8'hF0;
            12'hFF8: id_byte = 8'h05;
            12'hFFC: id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/crt_counter.sv
// Free-running up-counter of CNT_W bits.
// Assumes a synchronous active-low reset; advances only when tick_en is high.
module crt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt
);
    // Clear on reset, step by one on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick_en) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/crt_compare.sv
// One-shot compare unit: holds the absolute deadline, reports count >= deadline
// and gives the relative view. Assumes at most one write strobe per cycle.
module crt_compare #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_rel,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic              hit,
    output logic [DATA_W-1:0] rel_view
);
    logic [CNT_W-1:0] rel_ext;

    // Sign-extend the relative write value and form the comparisons.
    always_comb begin
        rel_ext  = {{DATA_W{wdata[DATA_W-1]}}, wdata};
        hit      = (cnt >= cmp);
        rel_view = cmp[DATA_W-1:0] - cnt[DATA_W-1:0];
    end

    // Update one half, or the whole value from the relative view.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp <= '0;
        else if (wr_lo)  cmp[DATA_W-1:0] <= wdata;
        else if (wr_hi)  cmp[CNT_W-1:DATA_W] <= wdata;
        else if (wr_rel) cmp <= cnt + rel_ext;
    end
endmodule

// File: rtl/crt_autoinc.sv
// Periodic unit: on-bit, sticky flag, self-reloading deadline and reload word.
// Assumes ctl_en and ctl_en_nxt come from the main control register.
module crt_autoinc #(
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ctl_en,
    input  logic              ctl_en_nxt,
    input  logic              wr_reload,
    input  logic              wr_actl,
    input  logic [DATA_W-1:0] wdata,
    output logic              aut_en,
    output logic              clr,
    output logic [CNT_W-1:0]  dl,
    output logic [DATA_W-1:0] reload
);
    logic aut_en_nxt, arm, expire, clr_nxt;

    // Decide whether this cycle arms, expires, or changes the flag.
    always_comb begin
        aut_en_nxt = wr_actl ? wdata[0] : aut_en;
        arm        = ctl_en_nxt && aut_en_nxt &&
                     ((ctl_en_nxt != ctl_en) || (aut_en_nxt != aut_en));
        expire     = ctl_en && aut_en && (cnt >= dl);
        clr_nxt    = clr;
        if (wr_actl && !wdata[1]) clr_nxt = 1'b0;
        if (expire)               clr_nxt = 1'b1;
    end

    // Hold the periodic-unit state; an expiry wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aut_en <= 1'b0;
            clr    <= 1'b0;
            dl     <= '0;
            reload <= '0;
        end else begin
            aut_en <= aut_en_nxt;
            clr    <= clr_nxt;
            if (arm || expire) dl <= cnt + CNT_W'(reload);
            if (wr_reload)     reload <= wdata;
        end
    end
endmodule

// File: rtl/cmp_reload_timer.sv
// Top of the compare and auto-reload system timer: bus decode, main control,
// frequency word, status and interrupt. Assumes word-aligned single-cycle
// accesses; read data is combinational on the presented address.
module cmp_reload_timer #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [crt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      irq
);
    import crt_pkg::*;
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt, cmp, dl;
    logic [DATA_W-1:0] rel_view, reload, freq;
    logic              hit, aut_en, clr, ctl_en, ctl_mask, ctl_en_nxt, status;
    logic              we, wr_cmp_lo, wr_cmp_hi, wr_rel, wr_ctrl, wr_freq;
    logic              wr_reload, wr_actl;

    // Decode write strobes for each writable offset.
    always_comb begin
        we         = bus_valid && bus_write;
        wr_freq    = we && (bus_addr == OFF_FREQ);
        wr_cmp_lo  = we && (bus_addr == OFF_CMP_LO);
        wr_cmp_hi  = we && (bus_addr == OFF_CMP_HI);
        wr_rel     = we && (bus_addr == OFF_REL);
        wr_ctrl    = we && (bus_addr == OFF_CTRL);
        wr_reload  = we && (bus_addr == OFF_RELOAD);
        wr_actl    = we && (bus_addr == OFF_AUTO_CTRL);
        ctl_en_nxt = wr_ctrl ? bus_wdata[0] : ctl_en;
    end

    crt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt)
    );

    crt_compare #(.DATA_W(DATA_W)) u_compare (
        .clk(clk), .rst_n(rst_n), .cnt(cnt),
        .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wr_rel(wr_rel),
        .wdata(bus_wdata), .cmp(cmp), .hit(hit), .rel_view(rel_view)
    );

    crt_autoinc #(.DATA_W(DATA_W)) u_autoinc (
        .clk(clk), .rst_n(rst_n), .cnt(cnt),
        .ctl_en(ctl_en), .ctl_en_nxt(ctl_en_nxt),
        .wr_reload(wr_reload), .wr_actl(wr_actl), .wdata(bus_wdata),
        .aut_en(aut_en), .clr(clr), .dl(dl), .reload(reload)
    );

    // Main control bits and frequency word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mask <= 1'b0;
            freq     <= '0;
        end else begin
            if (wr_ctrl) {ctl_mask, ctl_en} <= bus_wdata[1:0];
            if (wr_freq) freq <= bus_wdata;
        end
    end

    // Select the interrupt source and apply the mask.
    always_comb begin
        status = ctl_en && (aut_en ? clr : hit);
        irq    = status && !ctl_mask;
    end

    // Combinational read mux; unmapped and write-only offsets give 0.
    always_comb begin
        case (bus_addr)
            OFF_COUNT_LO:  bus_rdata = cnt[DATA_W-1:0];
            OFF_COUNT_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
            OFF_FREQ:      bus_rdata = freq;
            OFF_CMP_LO:    bus_rdata = cmp[DATA_W-1:0];
            OFF_CMP_HI:    bus_rdata = cmp[CNT_W-1:DATA_W];
            OFF_REL:       bus_rdata = rel_view;
            OFF_CTRL:      bus_rdata = {{(DATA_W-3){1'b0}}, status, ctl_mask, ctl_en};
            OFF_DL_LO:     bus_rdata = dl[DATA_W-1:0];
            OFF_DL_HI:     bus_rdata = dl[CNT_W-1:DATA_W];
            OFF_RELOAD:    bus_rdata = reload;
            OFF_CFG:       bus_rdata = DATA_W'(1);
            default:       bus_rdata = DATA_W'(id_byte(bus_addr));
        endcase
    end
endmodule

// File: rtl/crt_checker.sv
// Assertion checker for the timer, bound to the top so that it can observe
// the counter, deadline and control state. Holds no design state of its own.
module crt_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [11:0]      bus_addr,
    input logic             wd_clr_bit,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] dl,
    input logic             ctl_en,
    input logic             ctl_mask,
    input logic             aut_en,
    input logic             clr
);
    logic clr_zero_wr, due;
    assign clr_zero_wr = bus_valid && bus_write && (bus_addr == 12'h04C) && !wd_clr_bit;
    assign due         = ctl_en && aut_en && (cnt >= dl);

    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt == $past(cnt) + 1'b1));
    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !irq);
    a_r6_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_mask |-> !irq);
    a_r9_expiry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> clr);
    a_r9_flag_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && aut_en && !ctl_mask) |-> (irq == clr));
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_zero_wr && !due) |=> !clr);
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !clr_zero_wr) |=> clr);
endmodule

bind cmp_reload_timer crt_checker #(.CNT_W(2 * DATA_W)) u_crt_checker (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .wd_clr_bit(bus_wdata[1]), .irq(irq), .cnt(cnt), .dl(dl),
    .ctl_en(ctl_en), .ctl_mask(ctl_mask), .aut_en(aut_en), .clr(clr)
);

// File: tb/cmp_reload_timer_bench.sv
// Self-checking bench: a vector table with the counter frozen, then directed
// scenarios for the relative view, masking, periodic re-arm, mode switch, reset.
module cmp_reload_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;

    cmp_reload_timer u_cmp_reload_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Vector: {write, req number, addr, data, expected read}
    localparam logic [80:0] VECS [0:NVEC-1] = '{
        {1'b0, 4'd1,  12'h000, 32'h0,        32'h0},        // R1 reset count
        {1'b0, 4'd10, 12'h050, 32'h0,        32'h1},        // R10 config
        {1'b0, 4'd10, 12'hFD0, 32'h0,        32'h04},       // R10 first id
        {1'b0, 4'd10, 12'hFE0, 32'h0,        32'hB7},
        {1'b0, 4'd10, 12'hFF4, 32'h0,        32'hF0},
        {1'b0, 4'd10, 12'hFFC, 32'h0,        32'hB1},
        {1'b1, 4'd2,  12'h010, 32'h12345678, 32'h0},        // R2 frequency
        {1'b0, 4'd2,  12'h010, 32'h0,        32'h12345678},
        {1'b1, 4'd11, 12'h000, 32'h5,        32'h0},        // R11 RO write
        {1'b0, 4'd11, 12'h000, 32'h0,        32'h0},
        {1'b1, 4'd11, 12'h050, 32'h7,        32'h0},
        {1'b0, 4'd11, 12'h050, 32'h0,        32'h1},
        {1'b0, 4'd11, 12'h060, 32'h0,        32'h0},        // R11 unmapped
        {1'b1, 4'd3,  12'h020, 32'h100,      32'h0},        // R3 halves
        {1'b1, 4'd3,  12'h024, 32'h2,        32'h0},
        {1'b0, 4'd3,  12'h020, 32'h0,        32'h100},
        {1'b0, 4'd3,  12'h024, 32'h0,        32'h2},
        {1'b0, 4'd4,  12'h028, 32'h0,        32'h100},      // R4 relative read
        {1'b1, 4'd8,  12'h048, 32'h10,       32'h0},        // R8 reload
        {1'b0, 4'd8,  12'h048, 32'h0,        32'h10},
        {1'b0, 4'd7,  12'h04C, 32'h0,        32'h0},        // R7 reads 0
        {1'b1, 4'd5,  12'h02C, 32'hFFFFFFFC, 32'h0}         // R5 only bits 1:0
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 check(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic irq_is(input logic exp, input string req);
        @(negedge clk);
        bus_valid = 1'b0;
        #1 check(req, 64'(irq), 64'(exp));
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_is(1'b0, "R12 irq after reset");
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][80]) bus_wr(VECS[i][75:64], VECS[i][63:32]);
            else bus_rd(VECS[i][75:64], VECS[i][31:0], $sformatf("R%0d vec %0d", VECS[i][79:76], i));
        end
        bus_rd(12'h02C, 32'h0, "R5 status not writable");

        // R4: negative relative write fires at once (count 100, compare 90)
        tick(100);
        bus_rd(12'h000, 32'd100, "R1 count after 100 ticks");
        bus_wr(12'h02C, 32'h1);
        irq_is(1'b0, "R6 enabled below compare");
        bus_wr(12'h028, 32'hFFFFFFF6);
        irq_is(1'b1, "R4 negative relative fires");
        bus_rd(12'h020, 32'd90, "R4 compare low from relative");
        bus_rd(12'h024, 32'h0, "R4 compare high from relative");
        bus_rd(12'h028, 32'hFFFFFFF6, "R4 relative readback");
        bus_rd(12'h02C, 32'h5, "R6 status set");
        // R6: mask keeps status visible but drops irq
        bus_wr(12'h02C, 32'h3);
        irq_is(1'b0, "R6 masked irq");
        bus_rd(12'h02C, 32'h7, "R6 masked status visible");
        bus_wr(12'h02C, 32'h1);
        // R3/R6: low-half write moves compare ahead; count reaches it
        bus_wr(12'h020, 32'd200);
        irq_is(1'b0, "R3 compare moved ahead");
        tick(100);
        bus_rd(12'h000, 32'd200, "R1 count 200");
        irq_is(1'b1, "R6 count reached compare");

        // R8/R9: periodic unit, reload 5, count 200
        bus_wr(12'h048, 32'd5);
        bus_wr(12'h04C, 32'h1);
        bus_rd(12'h040, 32'd205, "R8 deadline armed");
        bus_rd(12'h044, 32'h0, "R8 deadline high");
        irq_is(1'b0, "R9 compare path silenced");
        bus_rd(12'h02C, 32'h1, "R9 status follows flag");
        tick(5);
        irq_is(1'b1, "R9 first expiry");
        bus_rd(12'h040, 32'd210, "R9 deadline reloaded");
        bus_rd(12'h02C, 32'h5, "R9 status from flag");
        bus_wr(12'h04C, 32'h3);
        irq_is(1'b1, "R7 write 1 keeps flag");
        bus_rd(12'h040, 32'd210, "R8 no rearm without change");
        bus_wr(12'h04C, 32'h1);
        irq_is(1'b0, "R7 write 0 clears flag");
        tick(5);
        irq_is(1'b1, "R9 second expiry");
        bus_rd(12'h040, 32'd215, "R9 second reload");

        // Mode switch back to compare (count 210 >= compare 200)
        bus_wr(12'h04C, 32'h0);
        irq_is(1'b1, "R9 compare path restored");
        bus_rd(12'h02C, 32'h5, "R6 compare status after switch");
        bus_wr(12'h020, 32'd1000);
        irq_is(1'b0, "R6 compare ahead again");
        bus_wr(12'h02C, 32'h0);
        // R8: arming by the main enable
        bus_wr(12'h048, 32'd7);
        bus_wr(12'h04C, 32'h1);
        bus_rd(12'h040, 32'd215, "R8 no arm while disabled");
        bus_rd(12'h02C, 32'h0, "R6 disabled status 0");
        bus_wr(12'h02C, 32'h1);
        bus_rd(12'h040, 32'd217, "R8 armed by enable");
        irq_is(1'b0, "R9 flag clear after arm");

        // R12: reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_rd(12'h000, 32'h0, "R12 count");
        bus_rd(12'h010, 32'h0, "R12 frequency");
        bus_rd(12'h020, 32'h0, "R12 compare");
        bus_rd(12'h02C, 32'h0, "R12 control");
        bus_rd(12'h040, 32'h0, "R12 deadline");
        bus_rd(12'h048, 32'h0, "R12 reload");
        irq_is(1'b0, "R12 irq");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule